// File: doc/BRIEF.md
# In-System Configuration Mode Tracker

This block follows the in-system configuration mode of a programmable device while a test-port controller drives it. It runs in the test clock domain. Its inputs are single-cycle pulses, already decoded by the controller: an enable instruction was executed, a disable instruction was executed, a disable instruction was loaded, or some other non-test instruction was executed. It also takes a Test-Logic-Reset indication, a success flag from the configuration engine and a startup-complete pulse.

The tracker is in one of four modes: Unprogrammed, Accessed, Complete and Operational. It keeps the enabled and done flags that tell these modes apart. It issues one-cycle requests that launch the shutdown and startup sequences, which are built elsewhere. It holds the device I/O disabled until a startup sequence has completed in Operational mode. CRC checking and the sequences themselves are outside this block.

Top module: `iscTracker`

## Requirements
- R1: After reset the mode is Unprogrammed (code 0), `iscEnabled` and `iscDone` are 0, `ioDisable` is 1, and neither request output is asserted. The mode codes are Unprogrammed 0, Accessed 1, Complete 2 and Operational 3.
- R2: An enable-executed pulse in Unprogrammed, Complete or Operational moves the tracker to Accessed and sets `iscEnabled` at the following clock edge. The same pulse in Accessed changes nothing.
- R3: An enable-executed pulse in Operational raises `shutdownReq` for exactly one cycle as the tracker enters Accessed, and `ioDisable` returns to 1.
- R4: In Accessed, a disable-executed pulse raises `startupReq` for one cycle if no startup is already pending. The later startup-complete pulse moves the tracker to Complete, clears `iscEnabled`, and loads `iscDone` from the configuration engine's success flag.
- R5: In Complete, an other-instruction pulse or Test-Logic-Reset moves the tracker to Operational when `iscDone` is 1 and to Unprogrammed when it is 0. A disable-loaded pulse keeps the tracker in Complete.
- R6: Test-Logic-Reset in Accessed clears `iscEnabled` and moves the tracker to Operational when `iscDone` is 1 and to Unprogrammed when it is 0.
- R7: In Operational, `ioDisable` stays 1 until a startup requested there by a disable-executed pulse completes. It then drops to 0.
- R8: An other-instruction pulse in Unprogrammed, Accessed or Operational leaves every output unchanged. So does a startup-complete pulse when no startup is pending.
- R9: `shutdownReq` and `startupReq` are never high for two consecutive cycles.
- R10: `iscEnabled` is 1 exactly in Accessed. `iscDone` is 0 in Unprogrammed and 1 in Operational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Power-up reset, asynchronous, active low |
| tlrIn | input | 1 | Controller is in Test-Logic-Reset |
| enExec | input | 1 | Enable instruction executed (pulse) |
| disExec | input | 1 | Disable instruction executed (pulse) |
| disLoad | input | 1 | Disable instruction loaded (pulse) |
| otherExec | input | 1 | Other non-test instruction executed (pulse) |
| cfgOk | input | 1 | Configuration engine reports success |
| startupDone | input | 1 | Startup sequence finished (pulse) |
| mode | output | 2 | Current mode code |
| iscEnabled | output | 1 | Enabled flag |
| iscDone | output | 1 | Done flag |
| shutdownReq | output | 1 | Launch the shutdown sequence (pulse) |
| startupReq | output | 1 | Launch the startup sequence (pulse) |
| ioDisable | output | 1 | Hold the device I/O inactive |

## Verification
A wrong mode shows on `mode` at the first clock edge after the stimulus that caused it. It also breaks the flag pairing: for example, `iscEnabled` goes high outside Accessed, or `iscDone` goes low in Operational. A pending-startup flag that is lost or stuck shows up later, at the next startup-complete pulse. Either Complete is never reached, or `ioDisable` never drops in Operational. The bench therefore checks every output on every cycle, and it places startup-complete pulses both with and without a request outstanding.

// File: rtl/iscPkg.sv
package iscPkg;
  typedef enum logic [1:0] {
    MODE_UNPROG = 2'd0,
    MODE_ACCESS = 2'd1,
    MODE_CMPLT  = 2'd2,
    MODE_OPER   = 2'd3
  } modeT;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic latchDone;
    logic clrDone;
    logic arm;
    logic disarm;
    logic ioOff;
    logic ioOn;
    logic shutReq;
    logic startReq;
  } strobeT;
endpackage

// File: rtl/iscControl.sv
module iscControl
  import iscPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tlrIn,
  input  logic   enExec,
  input  logic   disExec,
  input  logic   disLoad,
  input  logic   otherExec,
  input  logic   startupDone,
  input  logic   doneFlag,
  input  logic   pending,
  output modeT   modeQ,
  output strobeT stb
);
  modeT modeD;
  // On leaving Complete or Accessed via reset/resolve: done picks the exit.
  modeT resolveMode;

  always_comb resolveMode = doneFlag ? MODE_OPER : MODE_UNPROG;

  always_comb begin
    modeD = modeQ;
    stb   = '0;
    unique case (modeQ)
      MODE_UNPROG: begin
        if (!tlrIn && enExec) begin
          modeD     = MODE_ACCESS;
          stb.setEn = 1'b1;
        end
      end
      MODE_ACCESS: begin
        if (tlrIn) begin
          modeD      = resolveMode;
          stb.clrEn  = 1'b1;
          stb.disarm = 1'b1;
          stb.clrDone = !doneFlag;
        end else if (startupDone && pending) begin
          modeD         = MODE_CMPLT;
          stb.clrEn     = 1'b1;
          stb.latchDone = 1'b1;
          stb.disarm    = 1'b1;
        end else if (disExec && !pending) begin
          stb.arm      = 1'b1;
          stb.startReq = 1'b1;
        end
      end
      MODE_CMPLT: begin
        if (tlrIn || (otherExec && !disLoad)) begin
          modeD       = resolveMode;
          stb.clrDone = !doneFlag;
        end else if (enExec) begin
          modeD     = MODE_ACCESS;
          stb.setEn = 1'b1;
        end
      end
      MODE_OPER: begin
        if (!tlrIn && enExec) begin
          modeD       = MODE_ACCESS;
          stb.setEn   = 1'b1;
          stb.shutReq = 1'b1;
          stb.disarm  = 1'b1;
        end else if (!tlrIn && startupDone && pending) begin
          stb.ioOn   = 1'b1;
          stb.disarm = 1'b1;
        end else if (!tlrIn && disExec && !pending) begin
          stb.arm      = 1'b1;
          stb.startReq = 1'b1;
        end
      end
      default: modeD = MODE_UNPROG;
    endcase
    if (modeD != modeQ) stb.ioOff = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_UNPROG;
    else       modeQ <= modeD;
  end
endmodule

// File: rtl/iscDatapath.sv
module iscDatapath
  import iscPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  strobeT stb,
  input  logic   cfgOk,
  output logic   enFlag,
  output logic   doneFlag,
  output logic   pending,
  output logic   ioOffQ,
  output logic   shutPulse,
  output logic   startPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enFlag     <= 1'b0;
      doneFlag   <= 1'b0;
      pending    <= 1'b0;
      ioOffQ     <= 1'b1;
      shutPulse  <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      if (stb.setEn)          enFlag <= 1'b1;
      else if (stb.clrEn)     enFlag <= 1'b0;
      if (stb.latchDone)      doneFlag <= cfgOk;
      else if (stb.clrDone)   doneFlag <= 1'b0;
      if (stb.arm)            pending <= 1'b1;
      else if (stb.disarm)    pending <= 1'b0;
      if (stb.ioOff)          ioOffQ <= 1'b1;
      else if (stb.ioOn)      ioOffQ <= 1'b0;
      shutPulse  <= stb.shutReq;
      startPulse <= stb.startReq;
    end
  end
endmodule

// File: rtl/iscTracker.sv
module iscTracker
  import iscPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tlrIn,
  input  logic       enExec,
  input  logic       disExec,
  input  logic       disLoad,
  input  logic       otherExec,
  input  logic       cfgOk,
  input  logic       startupDone,
  output logic [1:0] mode,
  output logic       iscEnabled,
  output logic       iscDone,
  output logic       shutdownReq,
  output logic       startupReq,
  output logic       ioDisable
);
  modeT   modeQ;
  strobeT stb;
  logic   doneFlag;
  logic   pending;

  iscControl u_ctrl (
    .clk(clk), .rstN(rstN), .tlrIn(tlrIn), .enExec(enExec),
    .disExec(disExec), .disLoad(disLoad), .otherExec(otherExec),
    .startupDone(startupDone), .doneFlag(doneFlag), .pending(pending),
    .modeQ(modeQ), .stb(stb)
  );

  iscDatapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgOk(cfgOk),
    .enFlag(iscEnabled), .doneFlag(doneFlag), .pending(pending),
    .ioOffQ(ioDisable), .shutPulse(shutdownReq), .startPulse(startupReq)
  );

  assign mode    = modeQ;
  assign iscDone = doneFlag;
endmodule

// File: rtl/iscChecker.sv
module iscChecker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       iscEnabled,
  input logic       iscDone,
  input logic       shutdownReq,
  input logic       startupReq,
  input logic       ioDisable
);
  assert_enabled_pairs_R10: assert property (@(posedge clk) disable iff (!rstN)
    iscEnabled == (mode == 2'd1));
  assert_unprog_not_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |-> !iscDone);
  assert_oper_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |-> iscDone);
  assert_io_off_outside_oper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd3) |-> ioDisable);
  assert_shutdown_into_access_R3: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> (mode == 2'd1 && ioDisable));
  assert_shutdown_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !shutdownReq);
  assert_startup_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    startupReq |=> !startupReq);
endmodule

bind iscTracker iscChecker u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .iscEnabled(iscEnabled),
  .iscDone(iscDone), .shutdownReq(shutdownReq), .startupReq(startupReq),
  .ioDisable(ioDisable)
);

// File: tb/test_iscTracker.sv
module test_iscTracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tlrIn = 0, enExec = 0, disExec = 0, disLoad = 0, otherExec = 0;
  logic cfgOk = 0, startupDone = 0;
  logic [1:0] mode;
  logic iscEnabled, iscDone, shutdownReq, startupReq, ioDisable;

  always #2.5 clk = ~clk;

  iscTracker i_iscTracker (
    .clk(clk), .rstN(rstN), .tlrIn(tlrIn), .enExec(enExec),
    .disExec(disExec), .disLoad(disLoad), .otherExec(otherExec),
    .cfgOk(cfgOk), .startupDone(startupDone), .mode(mode),
    .iscEnabled(iscEnabled), .iscDone(iscDone), .shutdownReq(shutdownReq),
    .startupReq(startupReq), .ioDisable(ioDisable)
  );

  typedef struct packed {
    logic [1:0] m;
    logic en, dn, sh, st, io;
  } obsT;
  typedef struct {
    obsT   exp;
    string tag;
  } itemT;

  itemT queueQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Driver: apply one cycle of stimulus and queue what must follow it.
  task automatic step(input logic [6:0] stim, input obsT e, input string tag);
    itemT it;
    @(negedge clk);
    {tlrIn, enExec, disExec, disLoad, otherExec, cfgOk, startupDone} = stim;
    it.exp = e;
    it.tag = tag;
    queueQ.push_back(it);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #1;
    if (queueQ.size() > 0) begin
      itemT it;
      obsT got;
      it  = queueQ.pop_front();
      got = '{mode, iscEnabled, iscDone, shutdownReq, startupReq, ioDisable};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got m=%0d en=%b dn=%b sh=%b st=%b io=%b expected m=%0d en=%b dn=%b sh=%b st=%b io=%b",
          it.tag, got.m, got.en, got.dn, got.sh, got.st, got.io,
          it.exp.m, it.exp.en, it.exp.dn, it.exp.sh, it.exp.st, it.exp.io);
      end
    end
  end

  // stim bits: tlr en dis disLoad other cfgOk startupDone
  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({mode, iscEnabled, iscDone, shutdownReq, startupReq, ioDisable} !== 7'b00_00001) begin
      errors++;
      $display("FAIL R1 in reset: got %b expected 0000001",
        {mode, iscEnabled, iscDone, shutdownReq, startupReq, ioDisable});
    end
    rstN = 1'b1;
    step(7'b0000000, '{2'd0,0,0,0,0,1}, "R1 idle after reset");
    step(7'b0000100, '{2'd0,0,0,0,0,1}, "R8 other in Unprogrammed");
    step(7'b0000001, '{2'd0,0,0,0,0,1}, "R8 stray startupDone");
    step(7'b0100000, '{2'd1,1,0,0,0,1}, "R2 enable from Unprogrammed");
    step(7'b0100000, '{2'd1,1,0,0,0,1}, "R2 enable in Accessed");
    step(7'b0000100, '{2'd1,1,0,0,0,1}, "R8 other in Accessed");
    step(7'b0010000, '{2'd1,1,0,0,1,1}, "R4 startup request");
    step(7'b0010000, '{2'd1,1,0,0,0,1}, "R9 no repeat while pending");
    step(7'b0000011, '{2'd2,0,1,0,0,1}, "R4 complete with success");
    step(7'b0001000, '{2'd2,0,1,0,0,1}, "R5 disable loaded holds");
    step(7'b0000100, '{2'd3,0,1,0,0,1}, "R5 resolve to Operational");
    step(7'b0000100, '{2'd3,0,1,0,0,1}, "R8 other in Operational");
    step(7'b0010000, '{2'd3,0,1,0,1,1}, "R7 startup request in Operational");
    step(7'b0000000, '{2'd3,0,1,0,0,1}, "R7 io still off");
    step(7'b0000001, '{2'd3,0,1,0,0,0}, "R7 io active");
    step(7'b0100000, '{2'd1,1,1,1,0,1}, "R3 shutdown on enable");
    step(7'b0000000, '{2'd1,1,1,0,0,1}, "R9 shutdown single pulse");
    step(7'b1000000, '{2'd3,0,1,0,0,1}, "R6 TLR with done");
    step(7'b0100000, '{2'd1,1,1,1,0,1}, "R3 second shutdown");
    step(7'b0010000, '{2'd1,1,1,0,1,1}, "R4 startup again");
    step(7'b0000001, '{2'd2,0,0,0,0,1}, "R4 complete with failure");
    step(7'b1000000, '{2'd0,0,0,0,0,1}, "R5 TLR resolve to Unprogrammed");
    step(7'b0100000, '{2'd1,1,0,0,0,1}, "R2 enable again");
    step(7'b1000000, '{2'd0,0,0,0,0,1}, "R6 TLR without done");
    step(7'b0000000, '{2'd0,0,0,0,0,1}, "R1 settle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule